// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled program. A 32-bit counter counts down one step per clock from a programmable reload value. The first time it reaches zero, it raises an interrupt flag and starts again from the reload value. If it reaches zero a second time while the flag is still pending and the reset path is enabled, the block raises a system reset request. That request stays high until the block itself is reset. Software keeps the system alive by acknowledging the interrupt. The acknowledge also restarts the count.

All registers sit on a simple word-addressed bus with byte offsets. A write is a single-cycle strobe, and read data is a combinational function of the address. To guard against stray writes, the block has a write lock. While it is locked, every register write except a write to the lock register is dropped. A 32-bit key value opens the lock, and any other value closes it.

Top module: `wdl_top`

## Requirements
- R1: After reset the block is unlocked, the control register reads 0, and the load and count registers both read 0xFFFFFFFF. irq_o and rst_req_o are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value there locks it. Offset 0xC00 reads 1 while locked and 0 while unlocked.
- R3: While the block is locked, writes to the load (0x000), control (0x008) and interrupt-clear (0x00C) offsets change nothing.
- R4: While control bit 0 is 1, the count (read at 0x004) falls by one each clock. While bit 0 is 0, the count holds its value.
- R5: When the count is 0 in an enabled cycle, the next cycle holds the reload value in the count and the interrupt flag is set. With reload value L, expiries are therefore L+1 clocks apart.
- R6: An expiry that finds the flag already set, with control bit 1 at 1, sets rst_req_o. rst_req_o then stays high until rst_n. With bit 1 at 0, the same expiry leaves rst_req_o low.
- R7: irq_o equals the flag AND control bit 0. Bit 0 of offset 0x010 reads the flag, and bit 0 of offset 0x014 reads the flag AND control bit 0.
- R8: An unlocked write of any data to 0x00C clears the flag and reloads the count from the load register.
- R9: An unlocked write to 0x000 stores the value and places it in the count on the next cycle.
- R10: A load value of 0 is used as 1 for every reload. The load register still reads back 0.
- R11: Bits [11:2] of the address select the register, and bits [1:0] are ignored. Reads of 0x00C and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
Several properties are checked on every cycle by assertions:
- decrement and hold of the count;
- reload when the count reaches zero;
- reset request only after a pending flag, and never falling once high;
- flag cleared after an acknowledge;
- registers unchanged by a locked write.

Other behaviour needs whole sequences, so only the bench's scenarios can show it:
- the exact L+1 expiry spacing;
- a zero load acting as one;
- the lock key opening and closing access;
- a second expiry without bit 1 leaving reset low.

The bench runs a behavioural model alongside the design and compares every output on every clock.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

  localparam logic [AW-1:0] OFS_LOAD  = 12'h000;
  localparam logic [AW-1:0] OFS_COUNT = 12'h004;
  localparam logic [AW-1:0] OFS_CTRL  = 12'h008;
  localparam logic [AW-1:0] OFS_ACK   = 12'h00C;
  localparam logic [AW-1:0] OFS_RAW   = 12'h010;
  localparam logic [AW-1:0] OFS_MSK   = 12'h014;
  localparam logic [AW-1:0] OFS_LOCK  = 12'hC00;

  typedef struct packed {
    logic count_en;
    logic reset_en;
  } wdl_ctrl_t;

  typedef struct packed {
    logic load_wr;
    logic ack_wr;
  } wdl_cmd_t;
endpackage

// File: rtl/wdl_regfile.sv
module wdl_regfile
  import wdl_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output wdl_ctrl_t         ctrl_q,
  output wdl_cmd_t          cmd,
  output logic [DATA_W-1:0] reload_val
);
  localparam int unsigned WA = ADDR_W - 2;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] load_q;
  logic              lock_q;
  logic [WA-1:0]     word;
  logic              hit_load, hit_ctrl, hit_ack, hit_lock, open_wr;

  assign word     = addr[ADDR_W-1:2];
  assign hit_load = (word == OFS_LOAD[ADDR_W-1:2]);
  assign hit_ctrl = (word == OFS_CTRL[ADDR_W-1:2]);
  assign hit_ack  = (word == OFS_ACK[ADDR_W-1:2]);
  assign hit_lock = (word == OFS_LOCK[ADDR_W-1:2]);
  assign open_wr  = wr_en && !lock_q;

  assign cmd.load_wr = open_wr && hit_load;
  assign cmd.ack_wr  = open_wr && hit_ack;

  function automatic logic [DATA_W-1:0] floor_one(input logic [DATA_W-1:0] v);
    return (v == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : v;
  endfunction

  assign reload_val = cmd.load_wr ? floor_one(wdata) : floor_one(load_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= ONES;
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (wr_en && hit_lock) lock_q <= (wdata != KEY);
      if (cmd.load_wr) load_q <= wdata;
      if (open_wr && hit_ctrl) ctrl_q <= wdl_ctrl_t'({wdata[0], wdata[1]});
    end
  end

  always_comb begin
    rdata = '0;
    unique case (word)
      OFS_LOAD[ADDR_W-1:2]:  rdata = load_q;
      OFS_COUNT[ADDR_W-1:2]: rdata = count;
      OFS_CTRL[ADDR_W-1:2]:  rdata = {{(DATA_W-2){1'b0}}, ctrl_q.reset_en, ctrl_q.count_en};
      OFS_RAW[ADDR_W-1:2]:   rdata = {{(DATA_W-1){1'b0}}, flag};
      OFS_MSK[ADDR_W-1:2]:   rdata = {{(DATA_W-1){1'b0}}, flag & ctrl_q.count_en};
      OFS_LOCK[ADDR_W-1:2]:  rdata = {{(DATA_W-1){1'b0}}, lock_q};
      default:               rdata = '0;
    endcase
  end

  // R3: a write while locked leaves the stored registers untouched
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && !hit_lock) |=> ($stable(load_q) && $stable(ctrl_q)));
  // R2: the key always unlocks
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_lock && wdata == KEY) |=> !lock_q);
endmodule

// File: rtl/wdl_counter.sv
module wdl_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              reset_en,
  input  logic              reload,
  input  logic              ack,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              flag,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] ONES = '1;
  logic expire;

  assign expire = count_en && (count == '0) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= ONES;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (reload || expire)  count <= reload_val;
      else if (count_en)     count <= count - 1'b1;
      if (ack)               flag <= 1'b0;
      else if (expire)       flag <= 1'b1;
      if (expire && flag && reset_en) rst_req <= 1'b1;
    end
  end

  // R4: decrement while enabled
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !reload && count != '0) |=> (count == $past(count) - 1'b1));
  // R4: hold while disabled
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !reload) |=> $stable(count));
  // R5: reload and flag on expiry
  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && count == '0 && !reload) |=> (flag && count == $past(reload_val)));
  // R6: reset request only after a pending flag, and sticky
  p_rst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(flag && reset_en));
  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R8: acknowledge clears the flag
  p_ack_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !flag);
endmodule

// File: rtl/wdl_top.sv
module wdl_top
  import wdl_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdl_ctrl_t         ctrl;
  wdl_cmd_t          cmd;
  logic [DATA_W-1:0] count, reload_val;
  logic              flag;

  wdl_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .flag(flag), .rdata(bus_rdata),
    .ctrl_q(ctrl), .cmd(cmd), .reload_val(reload_val)
  );

  wdl_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(ctrl.count_en),
    .reset_en(ctrl.reset_en), .reload(cmd.load_wr || cmd.ack_wr),
    .ack(cmd.ack_wr), .reload_val(reload_val), .count(count),
    .flag(flag), .rst_req(rst_req_o)
  );

  assign irq_o = flag & ctrl.count_en;

  // R9: a load write lands in the count next cycle
  p_load_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load_wr |=> (count == (($past(bus_wdata) == '0) ? 1 : $past(bus_wdata))));
  // R7: no interrupt while counting is disabled
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !cmd.load_wr && !cmd.ack_wr && irq_o && !ctrl.count_en) |-> 1'b0);
endmodule

// File: tb/sim_wdl_top.sv
module sim_wdl_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  wdl_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit [31:0] m_load, m_cnt;
  bit [1:0]  m_ctrl;
  bit        m_lock, m_flag, m_rst;

  function automatic bit [31:0] at_least_one(bit [31:0] v);
    return (v == 0) ? 32'd1 : v;
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    case (a[11:2])
      10'h000: return m_load;
      10'h001: return m_cnt;
      10'h002: return {30'd0, m_ctrl};
      10'h004: return {31'd0, m_flag};
      10'h005: return {31'd0, m_flag & m_ctrl[0]};
      10'h300: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = '1; m_cnt = '1; m_ctrl = 0; m_lock = 0; m_flag = 0; m_rst = 0;
    end else begin
      bit ld, ak, ct, lk, ex;
      bit [31:0] rv;
      ld = bus_wr_en && !m_lock && bus_addr[11:2] == 10'h000;
      ct = bus_wr_en && !m_lock && bus_addr[11:2] == 10'h002;
      ak = bus_wr_en && !m_lock && bus_addr[11:2] == 10'h003;
      lk = bus_wr_en && bus_addr[11:2] == 10'h300;
      rv = ld ? at_least_one(bus_wdata) : at_least_one(m_load);
      ex = m_ctrl[0] && m_cnt == 0 && !(ld || ak);
      if (ex && m_flag && m_ctrl[1]) m_rst = 1;
      if (ak) m_flag = 0; else if (ex) m_flag = 1;
      if (ld || ak || ex) m_cnt = rv; else if (m_ctrl[0]) m_cnt = m_cnt - 1;
      if (ld) m_load = bus_wdata;
      if (ct) m_ctrl = bus_wdata[1:0];
      if (lk) m_lock = (bus_wdata != KEY);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && cycles > 2 && !done) begin
      chk("R7 irq_o", {31'd0, irq_o}, {31'd0, m_flag & m_ctrl[0]});
      chk("R6 rst_req_o", {31'd0, rst_req_o}, {31'd0, m_rst});
      chk("R4,R11 bus_rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic bus_write(bit [11:0] a, bit [31:0] d);
    @(negedge clk); #1;
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr_en = 0;
  endtask

  task automatic read_chk(string tag, bit [11:0] a, bit [31:0] exp);
    @(negedge clk); #1; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 5000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(2); #1 rst_n = 1;
    read_chk("R1 load", 12'h000, 32'hFFFFFFFF);
    read_chk("R1 count", 12'h004, 32'hFFFFFFFF);
    read_chk("R1 ctrl", 12'h008, 0);
    read_chk("R1 lock", 12'hC00, 0);
    chk("R1 outputs", {30'd0, irq_o, rst_req_o}, 0);

    bus_write(12'h000, 5);
    read_chk("R9 count after load", 12'h004, 5);
    idle(3);
    read_chk("R4 hold when off", 12'h004, 5);
    read_chk("R11 low bits ignored", 12'h006, 5);

    bus_write(12'h000, 0);
    read_chk("R10 load reads 0", 12'h000, 0);
    read_chk("R10 count is 1", 12'h004, 1);

    bus_write(12'h000, 3);
    bus_write(12'h008, 1);
    @(negedge clk); #1 bus_addr = 12'h004;
    idle(10);
    read_chk("R5 raw flag", 12'h010, 1);
    read_chk("R7 masked flag", 12'h014, 1);
    chk("R6 no reset without bit1", {31'd0, rst_req_o}, 0);
    bus_write(12'h008, 0);
    read_chk("R7 masked off", 12'h014, 0);
    chk("R7 irq off", {31'd0, irq_o}, 0);
    bus_write(12'h00C, 32'hDEAD);
    read_chk("R8 flag clear", 12'h010, 0);
    read_chk("R8 count reload", 12'h004, 3);
    read_chk("R11 ack reads 0", 12'h00C, 0);
    read_chk("R11 unmapped", 12'h020, 0);

    bus_write(12'hC00, 1);
    read_chk("R2 locked", 12'hC00, 1);
    bus_write(12'h008, 3);
    bus_write(12'h000, 9);
    read_chk("R3 ctrl kept", 12'h008, 0);
    read_chk("R3 load kept", 12'h000, 3);
    bus_write(12'hC00, KEY);
    read_chk("R2 unlocked", 12'hC00, 0);

    bus_write(12'h008, 3);
    @(negedge clk); #1 bus_addr = 12'h004;
    idle(3);
    chk("R5 single expiry no reset", {31'd0, rst_req_o}, 0);
    idle(6);
    chk("R6 reset asserted", {31'd0, rst_req_o}, 1);
    bus_write(12'h008, 0);
    bus_write(12'h00C, 0);
    idle(2);
    chk("R6 reset sticky", {31'd0, rst_req_o}, 1);
    idle(2);
    finish_run();
  end
endmodule